// File: doc/BRIEF.md
# Interrupt Acknowledge Router and Port Request Latch

This block sits next to a 68000-family processor with a 32-bit address bus and does two jobs. It watches for interrupt-acknowledge bus cycles. For the level being acknowledged, it drives exactly one active-low strobe: either the autovector request, so the processor builds the vector itself, or an acknowledge strobe to one of two serial controllers, which then place their own vector on the bus. The split between autovectored and device-vectored levels is a fixed parameter map. The default map sends levels 5 and 4 to the two serial controllers and every other non-zero level to the autovector.

The block also holds the parallel-port interrupt request and drives it onto level 2. A rising edge on the port event input sets the request. Any access to the port window with address bit 1 low clears it, whether the access is a read or a write. The reset value of the request is a parameter. The default is "asserted", which models a board where the request can come up set after power-on, so software must be able to clear it. A periodic timer pulse is registered and forwarded onto level 3.

Top module: `iack_irq_unit`

## Requirements
- R1: While and right after reset, `avec_n`, `sio0_iack_n`, `sio1_iack_n` and `irq3_n` are 1, and `irq2_n` equals the inverse of `PPT_RST_VAL`, which is 0 by default because the request resets asserted.
- R2: An acknowledge cycle is recognised only when `cpu_as_n` is 0, `cpu_fc` is 3'b111 and `cpu_addr[19:16]` is 4'hF. In any other cycle all three acknowledge outputs stay 1.
- R3: Acknowledging level 7, 6, 3, 2 or 1, with the level taken from `cpu_addr[3:1]`, drives `avec_n` to 0.
- R4: Acknowledging level 5 drives `sio0_iack_n` to 0.
- R5: Acknowledging level 4 drives `sio1_iack_n` to 0.
- R6: At most one acknowledge output is 0 at any time. Level 0 drives none of them.
- R7: An acknowledge output falls one clock after the qualifying cycle is sampled. It returns to 1 one clock after `cpu_as_n` is sampled high.
- R8: A rising edge on `port_evt` sets the port request, so `irq2_n` is 0 one clock after the edge is sampled.
- R9: The request clears one clock after a cycle with `cpu_as_n` low, `per_sel_n` low, `cpu_addr[15:11]` equal to 5'b00001 (offsets 0x0800 to 0x0FFF) and `cpu_addr[1]` equal to 0, provided the cycle is not an acknowledge cycle. An access with `cpu_addr[1]` equal to 1, or an access outside the window, leaves the request unchanged.
- R10: When a set and a clear occur in the same cycle, the request ends up set.
- R11: `irq3_n` is the inverse of `tick_in`, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_fc | input | 3 | Processor function code |
| cpu_addr | input | 32 | Processor address bus |
| cpu_as_n | input | 1 | Address strobe, active low |
| per_sel_n | input | 1 | Peripheral region chip select, active low |
| port_evt | input | 1 | Parallel-port event, synchronous |
| tick_in | input | 1 | Periodic timer interrupt pulse |
| avec_n | output | 1 | Autovector request, active low |
| sio0_iack_n | output | 1 | First serial controller acknowledge, active low |
| sio1_iack_n | output | 1 | Second serial controller acknowledge, active low |
| irq2_n | output | 1 | Level 2 interrupt request (parallel port), active low |
| irq3_n | output | 1 | Level 3 interrupt request (timer), active low |

## Verification
The assertions assume that every input is synchronous to `clk` and settled at each rising edge. They look back only one cycle, so they do not require the address or function code to stay stable while the strobe is low. The stimulus changes all inputs a short time after each rising edge. It mixes biased random cycles, which favour acknowledge encodings and the port window, with cycles that move the address in the middle of a strobe and with directed set/clear collisions. This covers those freedoms while staying within that sampling contract.

// File: rtl/iack_pkg.sv
package iack_pkg;

    typedef enum logic [1:0] {
        RT_AUTO = 2'd0,
        RT_SIO0 = 2'd1,
        RT_SIO1 = 2'd2,
        RT_NONE = 2'd3
    } route_e;

    typedef struct packed {
        logic avec_n;
        logic sio0_n;
        logic sio1_n;
    } ack_t;

    localparam ack_t ACK_IDLE = 3'b111;
    localparam int LVL_W = 3;
    localparam int LVL_N = 1 << LVL_W;

    function automatic route_e route_of(input logic [2*LVL_N-1:0] map, input logic [LVL_W-1:0] lvl);
        return route_e'(map[2*lvl +: 2]);
    endfunction

endpackage

// File: rtl/iack_decode.sv
module iack_decode
    import iack_pkg::*;
#(
    parameter int                SPACE_W = 4,
    parameter logic [2*LVL_N-1:0] ROUTE  = 16'h0603
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         fc,
    input  logic [SPACE_W-1:0] space,
    input  logic [LVL_W-1:0]   lvl,
    input  logic               as_n,
    output logic               hit,
    output ack_t               ack
);

    localparam logic [SPACE_W-1:0] SPACE_ALL = '1;

    ack_t lvl_ack [LVL_N];

    for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
        localparam route_e RT = route_e'(ROUTE[2*g +: 2]);
        assign lvl_ack[g] = '{avec_n: (RT != RT_AUTO),
                              sio0_n: (RT != RT_SIO0),
                              sio1_n: (RT != RT_SIO1)};
    end

    ack_t ack_d, ack_q;

    assign hit = !as_n && (fc == 3'b111) && (space == SPACE_ALL);

    always_comb begin
        ack_d = ack_q;
        if (hit) begin
            ack_d = lvl_ack[lvl];
        end else begin
            ack_d = ACK_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= ACK_IDLE;
        end else begin
            ack_q <= ack_d;
        end
    end

    assign ack = ack_q;

    // R7: strobe released after address strobe is seen high
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (ack_q == ACK_IDLE));

    // R2: any active strobe traces back to a qualified acknowledge cycle
    assert_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != ACK_IDLE) |-> $past(!as_n && (fc == 3'b111) && (space == SPACE_ALL)));

    // R6: never more than one strobe active
    assert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ack_q));

    // R3: autovector only for levels routed to it
    assert_avec_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_q.avec_n |-> (route_of(ROUTE, $past(lvl)) == RT_AUTO));

    // R4: first serial controller only for its level
    assert_sio0_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_q.sio0_n |-> (route_of(ROUTE, $past(lvl)) == RT_SIO0));

    // R5: second serial controller only for its level
    assert_sio1_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_q.sio1_n |-> (route_of(ROUTE, $past(lvl)) == RT_SIO1));

endmodule

// File: rtl/ppt_latch.sv
module ppt_latch #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic req
);

    typedef struct packed {
        logic evt_prev;
        logic req;
    } ppt_st_t;

    ppt_st_t st_d, st_q;
    logic    rise;

    assign rise = evt && !st_q.evt_prev;

    always_comb begin
        st_d          = st_q;
        st_d.evt_prev = evt;
        if (rise) begin
            st_d.req = 1'b1;
        end else if (clr) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.evt_prev <= 1'b0;
            st_q.req      <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    // R8 and R10: an event edge always leaves the request set, even against a clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !st_q.evt_prev) |=> req);

    // R9: a clear without a coincident edge drops the request
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(evt && !st_q.evt_prev)) |=> !req);

    // R8: the request only rises because of an event edge
    assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(evt));

endmodule

// File: rtl/iack_irq_unit.sv
module iack_irq_unit
    import iack_pkg::*;
#(
    parameter int                 ADDR_W      = 32,
    parameter int                 SPACE_LSB   = 16,
    parameter int                 SPACE_W     = 4,
    parameter int                 LVL_LSB     = 1,
    parameter logic [2*LVL_N-1:0] ROUTE       = 16'h0603,
    parameter logic [ADDR_W-1:0]  WIN_MASK    = 32'h0000_F800,
    parameter logic [ADDR_W-1:0]  WIN_BASE    = 32'h0000_0800,
    parameter int                 CLR_BIT     = 1,
    parameter logic               PPT_RST_VAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cpu_fc,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_as_n,
    input  logic              per_sel_n,
    input  logic              port_evt,
    input  logic              tick_in,
    output logic              avec_n,
    output logic              sio0_iack_n,
    output logic              sio1_iack_n,
    output logic              irq2_n,
    output logic              irq3_n
);

    typedef struct packed {
        logic tick;
    } top_st_t;

    top_st_t st_d, st_q;
    ack_t    ack;
    logic    iack_hit;
    logic    win_hit;
    logic    ppt_clr;
    logic    ppt_req;

    iack_decode #(
        .SPACE_W (SPACE_W),
        .ROUTE   (ROUTE)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .fc    (cpu_fc),
        .space (cpu_addr[SPACE_LSB +: SPACE_W]),
        .lvl   (cpu_addr[LVL_LSB +: LVL_W]),
        .as_n  (cpu_as_n),
        .hit   (iack_hit),
        .ack   (ack)
    );

    assign win_hit = ((cpu_addr & WIN_MASK) == WIN_BASE);
    assign ppt_clr = !cpu_as_n && !per_sel_n && win_hit && !cpu_addr[CLR_BIT] && !iack_hit;

    ppt_latch #(
        .RST_VAL (PPT_RST_VAL)
    ) u_ppt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (port_evt),
        .clr   (ppt_clr),
        .req   (ppt_req)
    );

    always_comb begin
        st_d      = st_q;
        st_d.tick = tick_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avec_n      = ack.avec_n;
    assign sio0_iack_n = ack.sio0_n;
    assign sio1_iack_n = ack.sio1_n;
    assign irq2_n      = !ppt_req;
    assign irq3_n      = !st_q.tick;

    // R11: a timer pulse shows on level 3 one clock later
    assert_tick_fwd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_in |=> !irq3_n);

    // R11: level 3 is quiet unless a pulse was present
    assert_tick_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> irq3_n);

    // R9: an access with the clear bit high never drops the request by itself
    assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq2_n && cpu_addr[CLR_BIT]) |=> !irq2_n);

endmodule

// File: tb/iack_irq_unit_tb.sv
module iack_irq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cpu_fc = 3'd0;
    logic [31:0] cpu_addr = 32'd0;
    logic        cpu_as_n = 1'b1;
    logic        per_sel_n = 1'b1;
    logic        port_evt = 1'b0;
    logic        tick_in = 1'b0;
    logic        avec_n, sio0_iack_n, sio1_iack_n, irq2_n, irq3_n;

    int n_chk = 0;
    int n_fail = 0;

    logic       m_ppt = 1'b1;
    logic       m_prev = 1'b0;
    logic [2:0] m_ack = 3'b111;
    logic       m_tick = 1'b0;

    always #4 clk = ~clk;

    iack_irq_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_fc      (cpu_fc),
        .cpu_addr    (cpu_addr),
        .cpu_as_n    (cpu_as_n),
        .per_sel_n   (per_sel_n),
        .port_evt    (port_evt),
        .tick_in     (tick_in),
        .avec_n      (avec_n),
        .sio0_iack_n (sio0_iack_n),
        .sio1_iack_n (sio1_iack_n),
        .irq2_n      (irq2_n),
        .irq3_n      (irq3_n)
    );

    function automatic logic is_iack(input logic [2:0] f, input logic [31:0] a, input logic as);
        return !as && (f == 3'b111) && (a[19:16] == 4'hF);
    endfunction

    // {avec_n, sio0_iack_n, sio1_iack_n}; R3 R4 R5 routing
    function automatic logic [2:0] exp_ack(input logic [2:0] f, input logic [31:0] a, input logic as);
        if (!is_iack(f, a, as)) return 3'b111;
        case (a[3:1])
            3'd5:    return 3'b101;
            3'd4:    return 3'b110;
            3'd0:    return 3'b111;
            default: return 3'b011;
        endcase
    endfunction

    function automatic logic exp_clr(input logic [2:0] f, input logic [31:0] a, input logic as, input logic sel);
        return !as && !sel && (a[15:11] == 5'b00001) && !a[1] && !is_iack(f, a, as);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] f, input logic [31:0] a, input logic as,
                         input logic sel, input logic ev, input logic tk, input string tag);
        logic rise;
        cpu_fc = f; cpu_addr = a; cpu_as_n = as; per_sel_n = sel; port_evt = ev; tick_in = tk;
        @(posedge clk);
        rise   = ev && !m_prev;
        if (rise) m_ppt = 1'b1;
        else if (exp_clr(f, a, as, sel)) m_ppt = 1'b0;
        m_prev = ev;
        m_ack  = exp_ack(f, a, as);
        m_tick = tk;
        #2;
        check({tag, " ack R2 R6 R7"}, {5'd0, avec_n, sio0_iack_n, sio1_iack_n}, {5'd0, m_ack});
        check({tag, " port R8 R9 R10"}, {7'd0, irq2_n}, {7'd0, !m_ppt});
        check({tag, " tick R11"}, {7'd0, irq3_n}, {7'd0, !m_tick});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset ack", {5'd0, avec_n, sio0_iack_n, sio1_iack_n}, 8'h07);
        check("R1 reset irq3", {7'd0, irq3_n}, 8'h01);
        check("R1 reset irq2", {7'd0, irq2_n}, 8'h00);
        rst_n = 1'b1;
        apply(3'd0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R1 idle");
        check("R1 held after reset", {7'd0, irq2_n}, 8'h00);

        // R9: software clears the power-on request; R9 with bit1 high first
        apply(3'd5, 32'h0000_0802, 1'b0, 1'b0, 1'b0, 1'b0, "R9 bit1 high keeps");
        check("R9 no clear bit1", {7'd0, irq2_n}, 8'h00);
        apply(3'd5, 32'h0001_1000, 1'b0, 1'b0, 1'b0, 1'b0, "R9 outside window");
        check("R9 no clear outside", {7'd0, irq2_n}, 8'h00);
        apply(3'd1, 32'h0000_0FFC, 1'b0, 1'b0, 1'b0, 1'b0, "R9 clear");
        check("R9 cleared", {7'd0, irq2_n}, 8'h01);

        // R3 R4 R5 R6 R7: sweep all levels
        for (int l = 0; l < 8; l++) begin
            apply(3'd7, 32'hFFFF_FFF0 | (l << 1), 1'b0, 1'b1, 1'b0, 1'b0, "R3 R4 R5 sweep");
            apply(3'd7, 32'hFFFF_FFF0 | (l << 1), 1'b1, 1'b1, 1'b0, 1'b0, "R7 release");
            check("R7 released", {5'd0, avec_n, sio0_iack_n, sio1_iack_n}, 8'h07);
        end
        apply(3'd7, 32'h000F_000A, 1'b0, 1'b1, 1'b0, 1'b0, "R4 level5");
        check("R4 sio0", {7'd0, sio0_iack_n}, 8'h00);
        apply(3'd7, 32'h000F_0008, 1'b0, 1'b1, 1'b0, 1'b0, "R5 level4");
        check("R5 sio1", {7'd0, sio1_iack_n}, 8'h00);
        apply(3'd6, 32'h000F_000E, 1'b0, 1'b1, 1'b0, 1'b0, "R2 wrong fc");
        check("R2 no ack", {5'd0, avec_n, sio0_iack_n, sio1_iack_n}, 8'h07);
        apply(3'd7, 32'h000E_000E, 1'b0, 1'b1, 1'b0, 1'b0, "R2 wrong space");
        check("R2 no ack space", {5'd0, avec_n, sio0_iack_n, sio1_iack_n}, 8'h07);
        apply(3'd7, 32'h000F_000E, 1'b1, 1'b1, 1'b0, 1'b0, "R2 idle");

        // R8: event edge sets; level held does not re-set after clear
        apply(3'd0, 32'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R8 set");
        check("R8 set", {7'd0, irq2_n}, 8'h00);
        apply(3'd1, 32'h0000_0800, 1'b0, 1'b0, 1'b1, 1'b0, "R8 level no reset");
        check("R8 held level cleared", {7'd0, irq2_n}, 8'h01);
        // R10: set and clear together
        apply(3'd1, 32'h0000_0800, 1'b0, 1'b1, 1'b0, 1'b0, "R10 prep");
        apply(3'd1, 32'h0000_0800, 1'b0, 1'b0, 1'b1, 1'b0, "R10 collide");
        check("R10 set wins", {7'd0, irq2_n}, 8'h00);

        // R11: timer pulses
        apply(3'd0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R11 pulse");
        check("R11 low", {7'd0, irq3_n}, 8'h00);
        apply(3'd0, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R11 gap");
        check("R11 high", {7'd0, irq3_n}, 8'h01);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  f;
            logic [31:0] a;
            int          pick;
            pick = int'($urandom_range(0, 9));
            a = $urandom;
            f = 3'($urandom);
            if (pick < 4) begin
                f = 3'd7;
                a[19:16] = 4'hF;
            end else if (pick < 7) begin
                a[15:11] = 5'b00001;
            end
            apply(f, a, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
                  ($urandom_range(0, 4) == 0), ($urandom_range(0, 7) == 0), "R3 R9 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule